// File: doc/BRIEF.md
# Shared RAM Access Arbiter

This block controls a single-port, byte-wide RAM that two processors share: a local I/O processor and a remote master processor. Each side raises a request together with a write strobe; a request with the strobe low is a read. The arbiter gives the RAM to one side at a time. It holds the other side with a wait line instead of refusing it, and grants it the RAM once the RAM is free.

For the side that owns the RAM, the arbiter drives the data gate enable and the gate direction. It also sets the address multiplexer select, so that this side's address bus reaches the RAM, and drives the RAM write enable. An owner keeps the RAM for as long as it holds its request. After a release the RAM stays idle for a programmable gap before the next grant. When both sides compete for a free RAM, the side not served most recently wins, and the I/O processor wins the first contest after reset. Every control output is registered, so every output follows the input that caused it by one clock.

Top module: `shram_arb`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: io_gate_o and ms_gate_o are never both 1.
- R3: A lone request to a free RAM, with no idle gap pending, gives that side's gate 1 and its wait 0 one clock later.
- R4: A request made while the other side owns the RAM gives that side's wait 1 one clock later. The wait stays 1 until that side's gate becomes 1.
- R5: A gate stays 1 for as long as its side keeps its request high.
- R6: When the owner drops its request, its gate falls one clock later. The RAM then stays ungranted for GAP_CYCLES clocks (default 1) before the next grant.
- R7: When both sides request a free RAM, the side not granted most recently wins. The first contest after reset goes to the I/O processor. The loser waits and is granted after the winner releases and the gap has passed.
- R8: addr_sel_o is 1 (master address bus) exactly while ms_gate_o is 1, and 0 otherwise (I/O address bus).
- R9: dir_o is 1 (processor toward RAM) while the owner's write strobe was high on the previous clock, and 0 (RAM toward processor) on a read or with no owner.
- R10: ram_we_o is 1 only when a gate is 1 and the owner's write strobe was high on the previous clock.
- R11: A side's wait is 1 exactly when that side requested on the previous clock and is not the owner. A wait is never 1 together with its own gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | I/O processor memory request |
| io_wr_i | input | 1 | I/O processor write strobe (0 = read) |
| ms_req_i | input | 1 | Master processor memory request |
| ms_wr_i | input | 1 | Master processor write strobe (0 = read) |
| io_wait_o | output | 1 | Stall to the I/O processor |
| ms_wait_o | output | 1 | Stall to the master processor |
| io_gate_o | output | 1 | I/O-side data gate enable |
| ms_gate_o | output | 1 | Master-side data gate enable |
| addr_sel_o | output | 1 | Address mux select, 1 = master address bus |
| dir_o | output | 1 | Gate direction, 1 = toward RAM |
| ram_we_o | output | 1 | RAM write enable |

## Verification
The bench goes after simultaneous requests, right after reset and again after each side has been served. A design with fixed priority would grant the I/O processor twice in a row here and starve the master. It checks the clock that follows a release: a design that skips the idle gap grants the waiting side one clock early, and a design that frees the RAM while the request is still high drops the owner in the middle of a transfer. Mixed reads and writes on both sides check that the write enable and the direction follow the owner's strobe and not the other side's. Long random stretches compare every output against a behavioural model on every clock.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_IO   = 2'd1,
    OWN_MS   = 2'd2
  } owner_e;
endpackage

// File: rtl/shram_grant.sv
module shram_grant
  import shram_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   io_req_i,
  input  logic   ms_req_i,
  output owner_e nxt_o
);
  localparam int CW = $clog2(GAP_CYCLES + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYCLES);

  owner_e        own_q, own_d;
  logic [CW-1:0] gap_q, gap_d;
  logic          pri_ms_q, pri_ms_d;

  always_comb begin
    own_d    = own_q;
    gap_d    = gap_q;
    pri_ms_d = pri_ms_q;
    unique case (own_q)
      OWN_IO: if (!io_req_i) begin own_d = OWN_NONE; gap_d = GAP_LOAD; end
      OWN_MS: if (!ms_req_i) begin own_d = OWN_NONE; gap_d = GAP_LOAD; end
      default: begin
        if (gap_q != '0) begin
          gap_d = gap_q - 1'b1;
        end else if (io_req_i && ms_req_i) begin
          own_d = pri_ms_q ? OWN_MS : OWN_IO;
        end else if (io_req_i) begin
          own_d = OWN_IO;
        end else if (ms_req_i) begin
          own_d = OWN_MS;
        end
        // prefer the other side in the next contest
        if (own_d != OWN_NONE) pri_ms_d = (own_d == OWN_IO);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q    <= OWN_NONE;
      gap_q    <= '0;
      pri_ms_q <= 1'b0;
    end else begin
      own_q    <= own_d;
      gap_q    <= gap_d;
      pri_ms_q <= pri_ms_d;
    end
  end

  assign nxt_o = own_d;
endmodule

// File: rtl/shram_drive.sv
module shram_drive
  import shram_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  owner_e nxt_i,
  input  logic   io_req_i,
  input  logic   io_wr_i,
  input  logic   ms_req_i,
  input  logic   ms_wr_i,
  output logic   io_wait_o,
  output logic   ms_wait_o,
  output logic   io_gate_o,
  output logic   ms_gate_o,
  output logic   addr_sel_o,
  output logic   dir_o,
  output logic   ram_we_o
);
  logic io_own, ms_own, wr_sel;

  always_comb begin
    io_own = (nxt_i == OWN_IO);
    ms_own = (nxt_i == OWN_MS);
    wr_sel = (io_own && io_wr_i) || (ms_own && ms_wr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_wait_o  <= 1'b0;
      ms_wait_o  <= 1'b0;
      io_gate_o  <= 1'b0;
      ms_gate_o  <= 1'b0;
      addr_sel_o <= 1'b0;
      dir_o      <= 1'b0;
      ram_we_o   <= 1'b0;
    end else begin
      io_wait_o  <= io_req_i && !io_own;
      ms_wait_o  <= ms_req_i && !ms_own;
      io_gate_o  <= io_own;
      ms_gate_o  <= ms_own;
      addr_sel_o <= ms_own;
      dir_o      <= wr_sel;
      ram_we_o   <= wr_sel;
    end
  end
endmodule

// File: rtl/shram_arb.sv
module shram_arb
  import shram_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_req_i,
  input  logic io_wr_i,
  input  logic ms_req_i,
  input  logic ms_wr_i,
  output logic io_wait_o,
  output logic ms_wait_o,
  output logic io_gate_o,
  output logic ms_gate_o,
  output logic addr_sel_o,
  output logic dir_o,
  output logic ram_we_o
);
  owner_e nxt;

  shram_grant #(.GAP_CYCLES(GAP_CYCLES)) u_grant (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .io_req_i (io_req_i),
    .ms_req_i (ms_req_i),
    .nxt_o    (nxt)
  );

  shram_drive u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nxt_i      (nxt),
    .io_req_i   (io_req_i),
    .io_wr_i    (io_wr_i),
    .ms_req_i   (ms_req_i),
    .ms_wr_i    (ms_wr_i),
    .io_wait_o  (io_wait_o),
    .ms_wait_o  (ms_wait_o),
    .io_gate_o  (io_gate_o),
    .ms_gate_o  (ms_gate_o),
    .addr_sel_o (addr_sel_o),
    .dir_o      (dir_o),
    .ram_we_o   (ram_we_o)
  );
endmodule

// File: rtl/shram_arb_chk.sv
module shram_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic io_req_i,
  input logic io_wr_i,
  input logic ms_req_i,
  input logic ms_wr_i,
  input logic io_wait_o,
  input logic ms_wait_o,
  input logic io_gate_o,
  input logic ms_gate_o,
  input logic addr_sel_o,
  input logic dir_o,
  input logic ram_we_o
);
  p_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_gate_o && ms_gate_o));

  p_we_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (io_gate_o || ms_gate_o));

  p_io_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_gate_o && io_req_i) |=> io_gate_o);

  p_ms_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_gate_o && ms_req_i) |=> ms_gate_o);

  p_busy_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_gate_o && io_req_i && ms_req_i) |=> ms_wait_o);

  p_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(io_gate_o) || $fell(ms_gate_o)) |=> !(io_gate_o || ms_gate_o));

  p_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_sel_o == ms_gate_o);

  p_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_gate_o |-> (dir_o == $past(io_wr_i)));

  p_wait_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wait_o && io_gate_o) && !(ms_wait_o && ms_gate_o));
endmodule

bind shram_arb shram_arb_chk u_chk (.*);

// File: tb/tb_shram_arb.sv
`timescale 1ns/1ps
module tb_shram_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req = 0, io_wr = 0, ms_req = 0, ms_wr = 0;
  logic io_wait, ms_wait, io_gate, ms_gate, addr_sel, dir, we;

  int checks = 0;
  int errors = 0;

  // behavioural model: owner 0 none, 1 io, 2 master
  int own = 0;
  int gap = 0;
  bit pri_ms = 0;
  bit e_iow, e_msw, e_iog, e_msg, e_sel, e_dir, e_we;

  always #2.5 clk = ~clk;

  shram_arb dut (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(io_req), .io_wr_i(io_wr), .ms_req_i(ms_req), .ms_wr_i(ms_wr),
    .io_wait_o(io_wait), .ms_wait_o(ms_wait), .io_gate_o(io_gate),
    .ms_gate_o(ms_gate), .addr_sel_o(addr_sel), .dir_o(dir), .ram_we_o(we)
  );

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, string name, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic model();
    int nxt;
    nxt = own;
    if (own == 1) begin
      if (!io_req) begin nxt = 0; gap = 1; end
    end else if (own == 2) begin
      if (!ms_req) begin nxt = 0; gap = 1; end
    end else if (gap > 0) begin
      gap--;
    end else begin
      if (io_req && ms_req) nxt = pri_ms ? 2 : 1;
      else if (io_req) nxt = 1;
      else if (ms_req) nxt = 2;
      if (nxt != 0) pri_ms = (nxt == 1);
    end
    own   = nxt;
    e_iog = (own == 1);
    e_msg = (own == 2);
    e_iow = io_req && own != 1;
    e_msw = ms_req && own != 2;
    e_sel = (own == 2);
    e_we  = (own == 1 && io_wr) || (own == 2 && ms_wr);
    e_dir = e_we;
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(bit ir, bit iw, bit mr, bit mw, string tag);
    io_req = ir; io_wr = iw; ms_req = mr; ms_wr = mw;
    model();
    @(negedge clk);
    chk(tag, "io_gate R2/R3/R5", io_gate, e_iog);
    chk(tag, "ms_gate R2/R3/R5", ms_gate, e_msg);
    chk(tag, "io_wait R4/R11", io_wait, e_iow);
    chk(tag, "ms_wait R4/R11", ms_wait, e_msw);
    chk(tag, "addr_sel R8", addr_sel, e_sel);
    chk(tag, "dir R9", dir, e_dir);
    chk(tag, "ram_we R10", we, e_we);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "io_gate", io_gate, 0);
    chk("R1", "ms_gate", ms_gate, 0);
    chk("R1", "waits", io_wait | ms_wait, 0);
    chk("R1", "sel/dir/we", addr_sel | dir | we, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");

    // R7: simultaneous from reset -> I/O first
    step(1, 1, 1, 0, "R7");
    chk("R7", "io wins first contest", io_gate, 1);
    step(1, 1, 1, 0, "R4");
    step(1, 0, 1, 1, "R9");
    step(0, 0, 1, 1, "R6");
    chk("R6", "gate fell after release", io_gate, 0);
    step(0, 0, 1, 1, "R6");
    chk("R6", "idle gap clock", ms_gate, 0);
    step(0, 0, 1, 1, "R7");
    chk("R7", "loser granted after gap", ms_gate, 1);
    step(0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");

    // R7: both again, master was last -> I/O wins
    step(1, 0, 1, 0, "R7");
    chk("R7", "alternation to io", io_gate, 1);
    step(0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, "R6");
    step(1, 0, 1, 1, "R7");
    chk("R7", "master after io", ms_gate, 1);
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R3");
    // lone master request to free RAM
    step(0, 0, 1, 1, "R3");
    chk("R3", "lone grant", ms_gate, 1);
    chk("R8", "master address selected", addr_sel, 1);
    step(1, 1, 1, 1, "R10");
    chk("R10", "io strobe ignored by master owner", we, 1);
    step(1, 1, 1, 0, "R10");
    chk("R10", "master read no we", we, 0);
    step(0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r[0] | (io_req & r[2]), r[1], r[2] | (ms_req & r[0]), r[3], "R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule